// File: doc/BRIEF.md
# Banked Register File Address Path

This block turns the 5-bit register field of an 8-bit controller's instructions into an access to one of three kinds of storage. The first kind is a small set of special registers that live outside the block. The second is a run of general-purpose bytes that every bank shares. The third is a set of banked general-purpose bytes, where two bits of the memory-select register pick the bank. The block contains the memory-select register and the 73-byte general-purpose store. The other special registers stay outside: the block gives them one-hot write and read strobes and takes back one read byte.

Direct address 00h is an indirect port. Any access to it is redirected to the 7-bit location held in the memory-select register. When that location has bit 4 clear, it folds onto the low common region whatever its bank bits are. A pointer that lands on the indirect port itself gives a null access. Reads are combinational in the same cycle. Writes take effect at the next rising clock edge.

Top module: `rf_bank_path`

## Requirements
- R1: Direct addresses 07h–0Fh reach the same shared byte whatever the bank bits hold. The physical RAM index is the address minus 7 (0–8).
- R2: Direct addresses 10h–1Fh reach the bank named by memory-select bits 6:5. The physical index is 9 + 16·bank + (address − 10h), which gives 9–72.
- R3: Direct addresses 01h, 02h, 03h, 05h and 06h are external special registers. A write raises bit n of `sfr_we`. A read raises bit n of `sfr_re` and returns `sfr_rdata`, where n is the address.
- R4: Address 04h reads and writes the memory-select register. Bits 6:0 are stored. Bit 7 always reads 1 and a write to it has no effect. The register changes only when it is written.
- R5: An access to address 00h goes to the 7-bit location given by memory-select bits 6:0, using the same mapping as R1–R4 and R7.
- R6: An indirect access whose pointer has bits 4:0 all zero, whatever its bank bits, reads 00h. A write through it raises no write enable and changes no state.
- R7: Indirect locations with bit 4 clear and nonzero bank bits (20h–2Fh, 40h–4Fh, 60h–6Fh) alias onto 00h–0Fh.
- R8: While `rst_n` is low at a rising edge, bank bits 6:5 are set to 11 and bits 4:0 keep their value. No write enable is raised while `rst_n` is low.
- R9: `rd_data` is 00h when `acc_rd` is low. At most one write enable is raised in any cycle.
- R10: Read data reflects state in the same cycle. A write lands at the next rising edge, so a read in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 5 | Direct register address from the instruction |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| sfr_rdata | input | 8 | Read data returned by the external special register selected by `sfr_re` |
| rd_data | output | 8 | Read data of the access |
| ram_we | output | 1 | Write enable of the general-purpose store |
| ram_idx | output | 7 | Physical general-purpose byte index |
| sfr_we | output | 7 | One-hot special register write enables, bit = address |
| sfr_re | output | 7 | One-hot special register read selects, bit = address |
| msel_q | output | 8 | Memory-select register as read back |

## Verification
The same byte patterns are written to the common and banked windows under bank values 0, 1 and 3. This separates a shared location from a banked one and shows that a bank switch leaves the common bytes alone. The indirect port is tried with pointers aimed at common bytes, banked bytes, the aliased gaps and the pointer register itself. Each of these shows whether redirection uses all seven pointer bits and folds the gaps correctly. A null pointer under two bank values, writes to the read-only top bit, a reset with a known low pointer field, and a read that shares its cycle with a write to the same location cover the edge cases.

// File: rtl/rf_bank_pkg.sv
// Package rf_bank_pkg
// Holds the types shared by the register file address path.
// Assumes nothing beyond the standard types.
package rf_bank_pkg;
    // Which kind of storage a decoded access reaches.
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,   // null access: reads zero, writes dropped
        RGN_SFR  = 2'd1,   // external special register
        RGN_PTR  = 2'd2,   // memory-select register
        RGN_RAM  = 2'd3    // general-purpose store
    } rgn_e;
endpackage

// File: rtl/rf_addr_decode.sv
// Module rf_addr_decode
// Resolves a direct register field into an effective 7-bit location and
// classifies it. Address 0 is redirected through the pointer. The upper half
// of the direct space takes its bank from the pointer. Effective locations
// with the half bit clear fold onto the low common region.
// Assumes COMMON_BASE > PTR_ADDR > 0 and BANK_BITS >= 1.
module rf_addr_decode
    import rf_bank_pkg::*;
#(
    parameter int DIR_AW      = 5,
    parameter int BANK_BITS   = 2,
    parameter int COMMON_BASE = 7,
    parameter int PTR_ADDR    = 4,
    parameter int RAM_AW      = 7,
    localparam int EFF_AW     = DIR_AW + BANK_BITS,
    localparam int LO_W       = DIR_AW - 1,
    localparam int HALF       = 1 << LO_W,
    localparam int COMMON_N   = HALF - COMMON_BASE
) (
    input  logic [DIR_AW-1:0] dir_addr,
    input  logic [EFF_AW-1:0] ptr_bits,
    output rgn_e              rgn,
    output logic [LO_W-1:0]   lo_idx,
    output logic [RAM_AW-1:0] ram_idx
);
    logic [EFF_AW-1:0]    eff;
    logic [BANK_BITS-1:0] bank;

    // Form the effective location: indirect, banked or plain direct.
    always_comb begin
        if (dir_addr == '0)
            eff = ptr_bits;
        else if (dir_addr[DIR_AW-1])
            eff = {ptr_bits[EFF_AW-1:DIR_AW], dir_addr};
        else
            eff = {{BANK_BITS{1'b0}}, dir_addr};
    end

    assign bank   = eff[EFF_AW-1:DIR_AW];
    assign lo_idx = eff[LO_W-1:0];

    // Classify the location and compute the physical byte index.
    always_comb begin
        ram_idx = '0;
        if (eff[DIR_AW-1]) begin
            rgn     = RGN_RAM;
            ram_idx = RAM_AW'(COMMON_N) + RAM_AW'({bank, lo_idx});
        end else if (lo_idx == '0) begin
            rgn = RGN_NONE;
        end else if (lo_idx == LO_W'(PTR_ADDR)) begin
            rgn = RGN_PTR;
        end else if (lo_idx < LO_W'(COMMON_BASE)) begin
            rgn = RGN_SFR;
        end else begin
            rgn     = RGN_RAM;
            ram_idx = RAM_AW'(lo_idx) - RAM_AW'(COMMON_BASE);
        end
    end
endmodule

// File: rtl/rf_msel_reg.sv
// Module rf_msel_reg
// Memory-select register: it holds the bank bits and the indirect pointer.
// Bits above EFF_AW are not implemented and read as ones. Reset loads the
// bank bits with ones and leaves the low pointer bits unchanged.
// Assumes DW >= EFF_AW.
module rf_msel_reg #(
    parameter int DW     = 8,
    parameter int DIR_AW = 5,
    parameter int EFF_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DW-1:0]     wdata,
    output logic [EFF_AW-1:0] ptr_bits,
    output logic [DW-1:0]     rd_val
);
    logic [EFF_AW-DIR_AW-1:0] bank_q;
    logic [DIR_AW-1:0]        low_q;

    // Bank bits: set to all ones on reset, loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '1;
        else if (we)
            bank_q <= wdata[EFF_AW-1:DIR_AW];
    end

    // Low pointer bits: no reset value, loaded on a write outside reset.
    always_ff @(posedge clk) begin
        if (rst_n && we)
            low_q <= wdata[DIR_AW-1:0];
    end

    assign ptr_bits = {bank_q, low_q};

    // Readback pads the unimplemented top bits with ones.
    generate
        if (DW > EFF_AW) begin : g_pad
            assign rd_val = {{(DW-EFF_AW){1'b1}}, ptr_bits};
        end else begin : g_full
            assign rd_val = ptr_bits;
        end
    endgenerate
endmodule

// File: rtl/rf_gpr_ram.sv
// Module rf_gpr_ram
// General-purpose byte store with an asynchronous read and a synchronous
// write. An index beyond DEPTH reads zero and is never written.
// Assumes the caller raises we only for valid indices.
module rf_gpr_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 73,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one byte when enabled.
    always_ff @(posedge clk) begin
        if (we && (idx < AW'(DEPTH)))
            mem[idx] <= wdata;
    end

    // Combinational read of the addressed byte.
    always_comb begin
        if (idx < AW'(DEPTH))
            rdata = mem[idx];
        else
            rdata = '0;
    end
endmodule

// File: rtl/rf_bank_path.sv
// Module rf_bank_path
// Top of the banked register file address path. It decodes the direct field,
// owns the memory-select register and the general-purpose store, and strobes
// the external special registers one-hot by address.
// Assumes the external special register returns its byte combinationally on
// sfr_rdata while its sfr_re bit is high.
module rf_bank_path
    import rf_bank_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DIR_AW      = 5,
    parameter int BANK_BITS   = 2,
    parameter int COMMON_BASE = 7,
    parameter int PTR_ADDR    = 4,
    localparam int LO_W       = DIR_AW - 1,
    localparam int HALF       = 1 << LO_W,
    localparam int NUM_BANKS  = 1 << BANK_BITS,
    localparam int COMMON_N   = HALF - COMMON_BASE,
    localparam int RAM_DEPTH  = COMMON_N + NUM_BANKS * HALF,
    localparam int RAM_AW     = $clog2(RAM_DEPTH),
    localparam int EFF_AW     = DIR_AW + BANK_BITS,
    localparam int SFR_N      = COMMON_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIR_AW-1:0] acc_addr,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DW-1:0]     acc_wdata,
    input  logic [DW-1:0]     sfr_rdata,
    output logic [DW-1:0]     rd_data,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_idx,
    output logic [SFR_N-1:0]  sfr_we,
    output logic [SFR_N-1:0]  sfr_re,
    output logic [DW-1:0]     msel_q
);
    rgn_e              rgn;
    logic [LO_W-1:0]   lo_idx;
    logic [EFF_AW-1:0] ptr_bits;
    logic [DW-1:0]     ram_q;
    logic              wr_ok;
    logic              ptr_we;

    rf_addr_decode #(
        .DIR_AW      (DIR_AW),
        .BANK_BITS   (BANK_BITS),
        .COMMON_BASE (COMMON_BASE),
        .PTR_ADDR    (PTR_ADDR),
        .RAM_AW      (RAM_AW)
    ) u_dec (
        .dir_addr (acc_addr),
        .ptr_bits (ptr_bits),
        .rgn      (rgn),
        .lo_idx   (lo_idx),
        .ram_idx  (ram_idx)
    );

    rf_msel_reg #(
        .DW     (DW),
        .DIR_AW (DIR_AW),
        .EFF_AW (EFF_AW)
    ) u_msel (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ptr_we),
        .wdata    (acc_wdata),
        .ptr_bits (ptr_bits),
        .rd_val   (msel_q)
    );

    rf_gpr_ram #(
        .DW    (DW),
        .DEPTH (RAM_DEPTH),
        .AW    (RAM_AW)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (acc_wdata),
        .rdata (ram_q)
    );

    // Writes are honoured only outside reset.
    assign wr_ok  = acc_wr && rst_n;
    assign ram_we = wr_ok && (rgn == RGN_RAM);
    assign ptr_we = wr_ok && (rgn == RGN_PTR);

    // One-hot strobes toward the external special registers.
    always_comb begin
        sfr_we = '0;
        sfr_re = '0;
        if (rgn == RGN_SFR) begin
            if (wr_ok)  sfr_we = SFR_N'(1) << lo_idx;
            if (acc_rd) sfr_re = SFR_N'(1) << lo_idx;
        end
    end

    // Read data steering; zero when no read is requested.
    always_comb begin
        rd_data = '0;
        if (acc_rd) begin
            unique case (rgn)
                RGN_SFR:  rd_data = sfr_rdata;
                RGN_PTR:  rd_data = msel_q;
                RGN_RAM:  rd_data = ram_q;
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/rf_bank_path_chk.sv
// Module rf_bank_path_chk
// Property checker for rf_bank_path, attached to every instance by bind.
// Assumes the default port meanings of the top module.
module rf_bank_path_chk #(
    parameter int DW          = 8,
    parameter int DIR_AW      = 5,
    parameter int BANK_BITS   = 2,
    parameter int COMMON_BASE = 7,
    localparam int EFF_AW     = DIR_AW + BANK_BITS,
    localparam int HALF       = 1 << (DIR_AW - 1),
    localparam int COMMON_N   = HALF - COMMON_BASE,
    localparam int RAM_DEPTH  = COMMON_N + (1 << BANK_BITS) * HALF,
    localparam int RAM_AW     = $clog2(RAM_DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIR_AW-1:0] acc_addr,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic [DW-1:0]     rd_data,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_idx,
    input logic [COMMON_BASE-1:0] sfr_we,
    input logic [COMMON_BASE-1:0] sfr_re,
    input logic [DW-1:0]     msel_q
);
    AST_COMMON_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !acc_addr[DIR_AW-1] && acc_addr != '0) |-> (ram_idx < RAM_AW'(COMMON_N))); // R1
    AST_BANK_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && acc_addr[DIR_AW-1]) |-> (ram_idx >= RAM_AW'(COMMON_N))); // R2
    AST_SFR_RE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sfr_re)); // R3
    AST_MSB_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        msel_q[DW-1:EFF_AW] == '1); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> $stable(msel_q)); // R4
    AST_NULL_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == '0 && msel_q[DIR_AW-1:0] == '0)
        |-> (rd_data == '0 && !ram_we && sfr_we == '0)); // R6
    AST_BANK_RESET: assert property (@(posedge clk)
        !rst_n |=> (msel_q[EFF_AW-1:DIR_AW] == '1)); // R8
    AST_NO_WE_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> (!ram_we && sfr_we == '0)); // R8
    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |-> (rd_data == '0 && sfr_re == '0)); // R9
    AST_ONE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sfr_we) + (ram_we ? 1 : 0)) <= 1); // R9
endmodule

bind rf_bank_path rf_bank_path_chk #(
    .DW          (DW),
    .DIR_AW      (DIR_AW),
    .BANK_BITS   (BANK_BITS),
    .COMMON_BASE (COMMON_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_addr (acc_addr),
    .acc_rd   (acc_rd),
    .acc_wr   (acc_wr),
    .rd_data  (rd_data),
    .ram_we   (ram_we),
    .ram_idx  (ram_idx),
    .sfr_we   (sfr_we),
    .sfr_re   (sfr_re),
    .msel_q   (msel_q)
);

// File: tb/test_rf_bank_path.sv
// Scoreboard bench for rf_bank_path: the driver computes the expected outputs
// from a model of the requirements and queues them; the monitor compares.
module test_rf_bank_path;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] acc_addr = '0;
    logic       acc_rd = 1'b0;
    logic       acc_wr = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] sfr_rdata;
    logic [7:0] rd_data;
    logic       ram_we;
    logic [6:0] ram_idx;
    logic [6:0] sfr_we;
    logic [6:0] sfr_re;
    logic [7:0] msel_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic [7:0] mask;
        logic       rwe;
        logic [6:0] idx;
        logic [6:0] swe;
        logic [6:0] sre;
    } exp_t;
    exp_t sb_q[$];

    logic [7:0] m_mem [128];
    logic [6:0] m_ptr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_bank_path i_rf_bank_path (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .sfr_rdata(sfr_rdata),
        .rd_data(rd_data), .ram_we(ram_we), .ram_idx(ram_idx),
        .sfr_we(sfr_we), .sfr_re(sfr_re), .msel_q(msel_q)
    );

    // External special registers answer C0h + their address (R3).
    always_comb begin
        sfr_rdata = 8'h00;
        for (int i = 0; i < 7; i++)
            if (sfr_re[i]) sfr_rdata = 8'hC0 | 8'(i);
    end

    task automatic op(input bit rd, input bit wr, input logic [4:0] a,
                      input logic [7:0] w, input string tag,
                      input logic [7:0] mask = 8'hFF);
        logic [6:0] e, key, ridx;
        logic [7:0] val;
        int cls;
        exp_t it;
        @(negedge clk);
        rst_n = 1'b1; acc_rd = rd; acc_wr = wr; acc_addr = a; acc_wdata = w;
        if (a == 5'd0)   e = m_ptr;
        else if (a[4])   e = {m_ptr[6:5], a};
        else             e = {2'b00, a};
        key = e[4] ? e : {3'b000, e[3:0]};
        if (key == 7'd0)      cls = 0;
        else if (key == 7'd4) cls = 2;
        else if (key < 7'd7)  cls = 1;
        else                  cls = 3;
        ridx = key[4] ? (7'd9 + 7'({key[6:5], key[3:0]})) : (key - 7'd7);
        case (cls)
            1:       val = 8'hC0 | {1'b0, key};
            2:       val = {1'b1, m_ptr};
            3:       val = m_mem[key];
            default: val = 8'h00;
        endcase
        it.tag  = tag;
        it.rd   = rd ? val : 8'h00;
        it.mask = mask;
        it.rwe  = wr && (cls == 3);
        it.idx  = ridx;
        it.swe  = (wr && cls == 1) ? (7'd1 << key[2:0]) : 7'd0;
        it.sre  = (rd && cls == 1) ? (7'd1 << key[2:0]) : 7'd0;
        sb_q.push_back(it);
        if (wr) begin
            if (cls == 3) m_mem[key] = w;
            else if (cls == 2) m_ptr = w[6:0];
        end
    endtask

    // One reset cycle with a write attempt that must be blocked (R8).
    task automatic do_reset(input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = 1'b0; acc_rd = 1'b0; acc_wr = 1'b1; acc_addr = 5'h07; acc_wdata = 8'h55;
        it.tag = tag; it.rd = 8'h00; it.mask = 8'hFF; it.rwe = 1'b0;
        it.idx = '0; it.swe = '0; it.sre = '0;
        sb_q.push_back(it);
        m_ptr[6:5] = 2'b11;
    endtask

    // Monitor: compare queued expectations away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (((rd_data & it.mask) != (it.rd & it.mask)) || (ram_we !== it.rwe) ||
                    (sfr_we !== it.swe) || (sfr_re !== it.sre) ||
                    (it.rwe && ram_idx !== it.idx)) begin
                    errors++;
                    $display("FAIL %s: actual rd=%h rwe=%b idx=%0d swe=%b sre=%b expected rd=%h(mask %h) rwe=%b idx=%0d swe=%b sre=%b",
                             it.tag, rd_data, ram_we, ram_idx, sfr_we, sfr_re,
                             it.rd, it.mask, it.rwe, it.idx, it.swe, it.sre);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset("R8 write blocked in reset");
        op(1, 0, 5'h04, 8'h00, "R8 R4 reset bank bits and top bit", 8'hE0);
        op(0, 1, 5'h04, 8'h00, "R4 select bank 0");
        op(1, 0, 5'h04, 8'h00, "R4 readback top bit set");
        op(0, 1, 5'h07, 8'h11, "R1 write first common byte");
        op(0, 1, 5'h0F, 8'h1F, "R1 write last common byte");
        op(0, 1, 5'h10, 8'h20, "R2 write bank0 first");
        op(0, 1, 5'h1F, 8'h2F, "R2 write bank0 last");
        op(0, 1, 5'h04, 8'h20, "R4 select bank 1");
        op(1, 0, 5'h04, 8'h00, "R4 readback bank 1");
        op(0, 1, 5'h10, 8'h30, "R2 write bank1 first");
        op(1, 0, 5'h07, 8'h00, "R1 common byte under bank 1");
        op(1, 0, 5'h10, 8'h00, "R2 bank1 readback");
        op(0, 1, 5'h04, 8'h60, "R4 select bank 3");
        op(0, 1, 5'h1F, 8'h77, "R2 write bank3 last");
        op(1, 0, 5'h0F, 8'h00, "R1 common last under bank 3");
        op(0, 1, 5'h04, 8'hFF, "R4 write all ones");
        op(1, 0, 5'h04, 8'h00, "R4 readback all ones");
        op(0, 1, 5'h04, 8'h00, "R4 back to bank 0");
        op(1, 0, 5'h10, 8'h00, "R2 bank0 kept apart from bank1");
        op(1, 0, 5'h1F, 8'h00, "R2 bank0 last kept");
        op(0, 1, 5'h04, 8'h07, "R5 pointer to 07h");
        op(1, 0, 5'h00, 8'h00, "R5 indirect read common");
        op(0, 1, 5'h00, 8'h99, "R5 indirect write common");
        op(1, 0, 5'h07, 8'h00, "R5 direct sees indirect write");
        op(0, 1, 5'h04, 8'h30, "R5 pointer to bank1 10h");
        op(1, 0, 5'h00, 8'h00, "R5 indirect read bank1");
        op(0, 1, 5'h04, 8'h7F, "R5 pointer to bank3 1Fh");
        op(1, 0, 5'h00, 8'h00, "R5 indirect read bank3");
        op(0, 1, 5'h04, 8'h00, "R6 null pointer bank0");
        op(1, 1, 5'h00, 8'hAB, "R6 null read and write");
        op(0, 1, 5'h04, 8'h40, "R6 null pointer bank2");
        op(1, 1, 5'h00, 8'hCD, "R6 null under bank bits");
        op(1, 0, 5'h04, 8'h00, "R6 pointer unchanged by null write");
        op(0, 1, 5'h04, 8'h27, "R7 pointer to alias 27h");
        op(1, 0, 5'h00, 8'h00, "R7 alias reaches common 07h");
        op(0, 1, 5'h04, 8'h43, "R7 pointer to alias 43h");
        op(1, 0, 5'h00, 8'h00, "R7 R3 alias reaches special 03h");
        op(0, 1, 5'h04, 8'h64, "R7 pointer to alias 64h");
        op(1, 0, 5'h00, 8'h00, "R7 alias reads pointer itself");
        op(0, 1, 5'h04, 8'h24, "R7 pointer to alias 24h");
        op(0, 1, 5'h00, 8'h07, "R7 alias writes pointer");
        op(1, 0, 5'h04, 8'h00, "R7 pointer rewritten via alias");
        op(0, 1, 5'h02, 8'h3C, "R3 special write 02h");
        op(1, 0, 5'h05, 8'h00, "R3 special read 05h");
        op(0, 0, 5'h07, 8'h00, "R9 idle read is zero");
        op(1, 1, 5'h07, 8'h5A, "R10 same-cycle read returns old");
        op(1, 0, 5'h07, 8'h00, "R10 write landed");
        op(0, 1, 5'h04, 8'h0A, "R8 pointer low bits 0Ah");
        do_reset("R8 second reset write blocked");
        op(1, 0, 5'h04, 8'h00, "R8 low bits kept over reset");
        op(1, 0, 5'h1F, 8'h00, "R8 R2 bank3 after reset");
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0; acc_addr = '0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule